// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block keeps the two threshold offsets that a FIFO's flag logic compares against: one marks how close to empty the queue may get before the almost-empty flag rises, the other how close to full before the almost-full flag rises. Master reset loads both offsets with one of two defaults, chosen by the load-select pin. The same reset fixes the programming method for the rest of the session: either one bit at a time through a serial chain, or a whole offset at a time from the parallel data bus.

In parallel mode, writes alternate between the two offsets, starting with the empty offset. Parallel readback has its own alternating selector and works in either mode. When load-select is high, the write and read enables are not programming requests. They pass straight through as strobes for the FIFO storage array, which sits outside this block together with the pointers and the flag comparators.

Top module: `fifo_ofs_prog`

## Requirements
- R1: During master reset (`mrst_n` low, sampled on a `wclk` edge), both offsets load 0x07F if `ld_sel` is low and 0x3FF if `ld_sel` is high.
- R2: On each reset `wclk` edge, the mode is taken from `sen_n`: low selects serial and high selects parallel. It stays fixed until the next master reset.
- R3: In serial mode, each `wclk` edge with `sen_n` low shifts `sdin` into a 26-bit chain. The new bit enters at bit 12 of the full offset, and every bit moves one place toward bit 0 of the empty offset. After 26 shifts, the first bit sent sits at empty bit 0 and the last at full bit 12.
- R4: In parallel mode, a `wclk` edge with `ld_sel` low, `wen_n` low and `ren_n` high writes the parallel data into one offset. After reset the first such write goes to the empty offset, and later writes alternate between full and empty.
- R5: A parallel write stores `din[12:0]` and ignores `din[17:13]`.
- R6: An `rclk` edge with `ld_sel` low, `ren_n` low and `wen_n` high loads `dout` with the selected offset in bits 12:0 and zeros in bits 17:13. After reset the first read returns the empty offset, and later reads alternate. At all other times `dout` holds its value, and reset clears it.
- R7: Parallel readback works in serial mode as well as in parallel mode.
- R8: Requests for the method not selected are ignored. In serial mode, parallel writes change neither offset nor the write alternation. In parallel mode, `sen_n` low shifts nothing.
- R9: `mem_wr` is high exactly when reset is inactive, `ld_sel` is high and `wen_n` is low. `mem_rd` is high exactly when reset is inactive, `ld_sel` is high and `ren_n` is low.
- R10: With `ld_sel` low, `wen_n` and `ren_n` both low is no operation: neither offset, nor `dout`, nor either strobe changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock; offsets, mode and serial chain |
| rclk | input | 1 | Read-side clock; readback path |
| mrst_n | input | 1 | Master reset, active low, synchronous to each clock |
| ld_sel | input | 1 | Load select: low for offset access, high for memory access; picks default at reset |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| sen_n | input | 1 | Serial enable, active low; picks the mode at reset |
| sdin | input | 1 | Serial data bit |
| din | input | 18 | Parallel data in |
| empty_ofs | output | 13 | Almost-empty threshold offset |
| full_ofs | output | 13 | Almost-full threshold offset |
| dout | output | 18 | Parallel readback data |
| mem_wr | output | 1 | Memory write strobe passed through |
| mem_rd | output | 1 | Memory read strobe passed through |

## Verification
Assertions check on every clock edge that the mode stays locked after reset, that offsets and the write alternation stay still in serial mode except during a shift, that `dout` holds unless a read fires and that each read flips the read selector, and that the memory strobes stay low when load-select is low or both enables are high. Only the bench scenarios can show the values themselves. These include the reset defaults, the order of bits through the 26-bit chain, which offset each alternating write or read reaches, the dropping of the upper data bits, and readback in serial mode. Both directed sequences and seeded random traffic in both modes are compared against a reference model.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

    typedef enum logic {
        PROG_SERIAL   = 1'b0,
        PROG_PARALLEL = 1'b1
    } prog_mode_e;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/fifo_ofs_wr.sv
module fifo_ofs_wr
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W = 13,
    parameter int DIN_W = 18,
    parameter logic [OFS_W-1:0] DEF_LO = 'h07F,
    parameter logic [OFS_W-1:0] DEF_HI = 'h3FF
) (
    input  logic             wclk,
    input  logic             mrst_n,
    input  logic             ld_sel,
    input  logic             wen_n,
    input  logic             ren_n,
    input  logic             sen_n,
    input  logic             sdin,
    input  logic [DIN_W-1:0] din,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs
);
    localparam int CHAIN_W = 2 * OFS_W;

    typedef struct packed {
        prog_mode_e       mode;
        ofs_sel_e         wsel;
        logic [OFS_W-1:0] full;
        logic [OFS_W-1:0] empty;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      ser_fire;
    logic      par_fire;
    logic [CHAIN_W-1:0] chain_cur;
    logic [CHAIN_W-1:0] chain_nxt;

    always_comb begin
        ser_fire  = (st_q.mode == PROG_SERIAL) && !sen_n;
        par_fire  = (st_q.mode == PROG_PARALLEL) && !ld_sel && !wen_n && ren_n;
        chain_cur = {st_q.full, st_q.empty};
        chain_nxt = {sdin, chain_cur[CHAIN_W-1:1]};
        st_d      = st_q;
        if (!mrst_n) begin
            st_d.mode  = sen_n ? PROG_PARALLEL : PROG_SERIAL;
            st_d.wsel  = SEL_EMPTY;
            st_d.empty = ld_sel ? DEF_HI : DEF_LO;
            st_d.full  = ld_sel ? DEF_HI : DEF_LO;
        end else if (ser_fire) begin
            st_d.full  = chain_nxt[CHAIN_W-1:OFS_W];
            st_d.empty = chain_nxt[OFS_W-1:0];
        end else if (par_fire) begin
            if (st_q.wsel == SEL_FULL) begin
                st_d.full = din[OFS_W-1:0];
                st_d.wsel = SEL_EMPTY;
            end else begin
                st_d.empty = din[OFS_W-1:0];
                st_d.wsel  = SEL_FULL;
            end
        end
    end

    always_ff @(posedge wclk) begin
        st_q <= st_d;
    end

    assign empty_ofs = st_q.empty;
    assign full_ofs  = st_q.full;

    AST_MODE_LOCK: assert property (@(posedge wclk) disable iff (!mrst_n)
        1'b1 |=> $stable(st_q.mode)); // R2

    AST_SER_HOLD: assert property (@(posedge wclk) disable iff (!mrst_n)
        (st_q.mode == PROG_SERIAL && sen_n) |=> ($stable(empty_ofs) && $stable(full_ofs))); // R8

    AST_SER_WSEL_FROZEN: assert property (@(posedge wclk) disable iff (!mrst_n)
        (st_q.mode == PROG_SERIAL) |=> $stable(st_q.wsel)); // R8

    AST_PAR_IDLE_HOLD: assert property (@(posedge wclk) disable iff (!mrst_n)
        (st_q.mode == PROG_PARALLEL && (ld_sel || wen_n || !ren_n))
        |=> ($stable(empty_ofs) && $stable(full_ofs))); // R10

endmodule

// File: rtl/fifo_ofs_rd.sv
module fifo_ofs_rd
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W  = 13,
    parameter int DOUT_W = 18
) (
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              ld_sel,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    output logic [DOUT_W-1:0] dout
);
    localparam int PAD_W = DOUT_W - OFS_W;

    typedef struct packed {
        ofs_sel_e          rsel;
        logic [DOUT_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      rd_fire;

    always_comb begin
        rd_fire = !ld_sel && !ren_n && wen_n;
        st_d    = st_q;
        if (!mrst_n) begin
            st_d.rsel = SEL_EMPTY;
            st_d.data = '0;
        end else if (rd_fire) begin
            if (st_q.rsel == SEL_FULL) begin
                st_d.data = {{PAD_W{1'b0}}, full_ofs};
                st_d.rsel = SEL_EMPTY;
            end else begin
                st_d.data = {{PAD_W{1'b0}}, empty_ofs};
                st_d.rsel = SEL_FULL;
            end
        end
    end

    always_ff @(posedge rclk) begin
        st_q <= st_d;
    end

    assign dout = st_q.data;

    AST_RD_TOGGLE: assert property (@(posedge rclk) disable iff (!mrst_n)
        rd_fire |=> (st_q.rsel != $past(st_q.rsel))); // R6

    AST_RD_HOLD: assert property (@(posedge rclk) disable iff (!mrst_n)
        !rd_fire |=> ($stable(dout) && $stable(st_q.rsel))); // R10

endmodule

// File: rtl/fifo_ofs_memgate.sv
module fifo_ofs_memgate (
    input  logic mrst_n,
    input  logic ld_sel,
    input  logic wen_n,
    input  logic ren_n,
    output logic mem_wr,
    output logic mem_rd
);
    always_comb begin
        mem_wr = mrst_n && ld_sel && !wen_n;
        mem_rd = mrst_n && ld_sel && !ren_n;
    end
endmodule

// File: rtl/fifo_ofs_prog.sv
module fifo_ofs_prog
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W = 13,
    parameter int BUS_W = 18,
    parameter logic [OFS_W-1:0] DEF_LO = 'h07F,
    parameter logic [OFS_W-1:0] DEF_HI = 'h3FF
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst_n,
    input  logic             ld_sel,
    input  logic             wen_n,
    input  logic             ren_n,
    input  logic             sen_n,
    input  logic             sdin,
    input  logic [BUS_W-1:0] din,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic [BUS_W-1:0] dout,
    output logic             mem_wr,
    output logic             mem_rd
);
    fifo_ofs_wr #(
        .OFS_W (OFS_W),
        .DIN_W (BUS_W),
        .DEF_LO(DEF_LO),
        .DEF_HI(DEF_HI)
    ) u_wr (
        .wclk     (wclk),
        .mrst_n   (mrst_n),
        .ld_sel   (ld_sel),
        .wen_n    (wen_n),
        .ren_n    (ren_n),
        .sen_n    (sen_n),
        .sdin     (sdin),
        .din      (din),
        .empty_ofs(empty_ofs),
        .full_ofs (full_ofs)
    );

    fifo_ofs_rd #(
        .OFS_W (OFS_W),
        .DOUT_W(BUS_W)
    ) u_rd (
        .rclk     (rclk),
        .mrst_n   (mrst_n),
        .ld_sel   (ld_sel),
        .wen_n    (wen_n),
        .ren_n    (ren_n),
        .empty_ofs(empty_ofs),
        .full_ofs (full_ofs),
        .dout     (dout)
    );

    fifo_ofs_memgate u_gate (
        .mrst_n(mrst_n),
        .ld_sel(ld_sel),
        .wen_n (wen_n),
        .ren_n (ren_n),
        .mem_wr(mem_wr),
        .mem_rd(mem_rd)
    );

    AST_MEM_IDLE: assert property (@(posedge wclk) disable iff (!mrst_n)
        (wen_n && ren_n) |-> (!mem_wr && !mem_rd)); // R9

    AST_MEM_LD_LOW: assert property (@(posedge wclk) disable iff (!mrst_n)
        !ld_sel |-> (!mem_wr && !mem_rd)); // R10

endmodule

// File: tb/fifo_ofs_prog_tb.sv
`timescale 1ns/1ps
module fifo_ofs_prog_tb;
    logic        clk = 1'b0;
    logic        mrst_n = 1'b0;
    logic        ld_sel = 1'b0;
    logic        wen_n = 1'b1;
    logic        ren_n = 1'b1;
    logic        sen_n = 1'b1;
    logic        sdin = 1'b0;
    logic [17:0] din = '0;
    logic [12:0] empty_ofs, full_ofs;
    logic [17:0] dout;
    logic        mem_wr, mem_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    logic        m_mode;   // 1 = parallel
    logic        m_wsel, m_rsel;
    logic [12:0] m_emp, m_full;
    logic [17:0] m_dout;

    always #2.5 clk = ~clk;

    fifo_ofs_prog u_dut (
        .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .ld_sel(ld_sel),
        .wen_n(wen_n), .ren_n(ren_n), .sen_n(sen_n), .sdin(sdin), .din(din),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .dout(dout),
        .mem_wr(mem_wr), .mem_rd(mem_rd)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [12:0] dflt(input logic ld);
        return ld ? 13'h3FF : 13'h07F;
    endfunction

    task automatic model_edge();
        logic [12:0] oe, of;
        logic [25:0] ch;
        oe = m_emp; of = m_full;
        if (!mrst_n) begin
            m_mode = sen_n; m_wsel = 0; m_rsel = 0; m_dout = '0;
            m_emp = dflt(ld_sel); m_full = dflt(ld_sel);
        end else begin
            if (!ld_sel && !ren_n && wen_n) begin
                m_dout = {5'b0, m_rsel ? of : oe};
                m_rsel = ~m_rsel;
            end
            if (!m_mode && !sen_n) begin
                ch = {sdin, of, oe} >> 1;
                m_full = ch[25:13]; m_emp = ch[12:0];
            end else if (m_mode && !ld_sel && !wen_n && ren_n) begin
                if (m_wsel) m_full = din[12:0]; else m_emp = din[12:0];
                m_wsel = ~m_wsel;
            end
        end
    endtask

    // called just after a falling edge
    task automatic step(input string tag, input logic ld, input logic wn,
                        input logic rn, input logic sn, input logic sd,
                        input logic [17:0] d);
        ld_sel = ld; wen_n = wn; ren_n = rn; sen_n = sn; sdin = sd; din = d;
        #1;
        chk("R9 mem_wr", {17'b0, mem_wr}, {17'b0, mrst_n & ld & ~wn});
        chk("R9 mem_rd", {17'b0, mem_rd}, {17'b0, mrst_n & ld & ~rn});
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " empty_ofs"}, {5'b0, empty_ofs}, {5'b0, m_emp});
        chk({tag, " full_ofs"},  {5'b0, full_ofs},  {5'b0, m_full});
        chk({tag, " dout"}, dout, m_dout);
    endtask

    task automatic do_reset(input logic ld, input logic sn);
        mrst_n = 1'b0;
        for (int i = 0; i < 3; i++) step("R1 reset", ld, 1'b1, 1'b1, sn, 1'b0, '0);
        chk("R1 default empty", {5'b0, empty_ofs}, {5'b0, ld ? 13'h3FF : 13'h07F});
        chk("R1 default full",  {5'b0, full_ofs},  {5'b0, ld ? 13'h3FF : 13'h07F});
        chk("R6 dout cleared", dout, 18'h0);
        mrst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [25:0] pat;
        void'($urandom(32'd20240611));
        @(negedge clk);

        // serial mode, low default
        do_reset(1'b0, 1'b0);
        pat = 26'h2B5_C3A9;
        for (int i = 0; i < 26; i++) step("R3 shift", 1'b0, 1'b1, 1'b1, 1'b0, pat[i], '0);
        chk("R3 empty after chain", {5'b0, empty_ofs}, {5'b0, pat[12:0]});
        chk("R3 full after chain",  {5'b0, full_ofs},  {5'b0, pat[25:13]});
        step("R8 par write in serial", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h01234);
        chk("R8 empty untouched", {5'b0, empty_ofs}, {5'b0, pat[12:0]});
        step("R7 read empty", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        chk("R7 readback empty", dout, {5'b0, pat[12:0]});
        step("R7 read full", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        chk("R7 readback full", dout, {5'b0, pat[25:13]});
        for (int i = 0; i < 5; i++) step("R3 partial", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '0);

        // parallel mode, high default
        do_reset(1'b1, 1'b1);
        step("R8 sen in parallel", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R8 no shift", {5'b0, empty_ofs}, {5'b0, 13'h3FF});
        step("R5 write empty", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h3E123);
        chk("R5 upper bits dropped", {5'b0, empty_ofs}, {5'b0, 13'h0123});
        step("R10 both low", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00555);
        chk("R10 full untouched", {5'b0, full_ofs}, {5'b0, 13'h3FF});
        chk("R10 dout untouched", dout, 18'h0);
        step("R4 write full", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h01FFF);
        chk("R4 second write to full", {5'b0, full_ofs}, {5'b0, 13'h1FFF});
        step("R4 write empty again", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h00042);
        chk("R4 third write to empty", {5'b0, empty_ofs}, {5'b0, 13'h0042});
        step("R6 read empty", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        chk("R6 first read empty", dout, 18'h00042);
        step("R9 mem write", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h3FFFF);
        chk("R9 offsets untouched", {5'b0, full_ofs}, {5'b0, 13'h1FFF});
        step("R6 read full", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        chk("R6 second read full", dout, 18'h01FFF);

        // seeded random traffic in both modes
        for (int r = 0; r < 8; r++) begin
            do_reset(1'($urandom % 2), 1'(r % 2));
            for (int c = 0; c < 400; c++) begin
                step((r % 2) ? "R4 random" : "R3 random",
                     ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
                     ($urandom % 3) == 0, 1'($urandom % 2), 18'($urandom));
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule